// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of an SDRAM device on every rising clock edge. It turns them into a decoded command code and keeps a model of the device's command-side state. That state covers whether each of the four banks is open and which row it holds, the programmed mode word, the short lockout that follows a mode write, and whether the device is in self refresh or power-down. The model does not cover storage, analog timing or electrical behaviour.

A controller under test, or a memory model built around this block, drives the same pins it would drive into a real device. The block reports every command that breaks the legality rules on a one-cycle error output. It refuses to apply an illegal command to its own state, so later protocol checks stay trustworthy.

Auto precharge is modelled with the programmed burst length. A read or write that requests it keeps its bank reserved for the length of the burst and then closes the bank without a precharge command. A two-stage path reproduces the read-side latency of the data mask.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A command is decoded when CKE was high at the previous edge and is still high. With cs_n high the command is deselect. With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 111 no-op, 000 mode write, 001 auto refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop. The code is presented on cmd_o after the sampling edge, using these values: 0 no-op, 1 deselect, 2 mode write, 3 auto refresh, 4 self-refresh entry, 5 self-refresh exit, 6 activate, 7 read, 8 write, 9 precharge one bank, 10 precharge all, 11 burst stop, 12 power-down entry, 13 power-down exit, 14 held (CKE low).
- R2: When CKE falls (high at the previous edge, low now), a refresh pin pattern means self-refresh entry and any other pattern means power-down entry. While CKE was low at the previous edge, commands are ignored (code 14) and change no bank state. A rising CKE ends the low-power state (code 5 or 13). sref_o and pdn_o show the state.
- R3: Mode write, auto refresh and self-refresh entry are legal only when every bank is idle. When one of them is illegal, err_o is raised and the command has no effect. An illegal self-refresh entry leaves the device in power-down.
- R4: For the two edges after an accepted mode write, any command other than no-op, deselect or a CKE change raises err_o and is not applied.
- R5: Activate opens bank ba (00 to 11 selecting banks 0 to 3) and stores addr as its open row, visible at row_o[ba*12 +: 12]. Activate to a bank that is already open raises err_o.
- R6: Read or write to an idle bank raises err_o. An accepted read or write loads addr[8:0] into col_o.
- R7: Precharge with addr[10] high closes every bank and ignores ba. With addr[10] low it closes only bank ba. Precharging an idle bank is legal.
- R8: Read or write with addr[10] high requests auto precharge. The burst length comes from mode bits [2:0]: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives a full page of 256, and any other value gives 1. The bank closes at the BL-th edge after the command. Any read, write or activate to it sampled at edges 1 to BL after the command raises err_o.
- R9: err_o is asserted for exactly the cycle after the edge that sampled the offending command.
- R10: An accepted mode write loads {ba, addr} (14 bits) into mode_o.
- R11: dqm sampled at edge n appears on rd_mask_o after edge n+1 and is replaced after edge n+2.
- R12: While rst is high at an edge, all banks go idle and the lockout clears. mode_o, col_o, rd_mask_o, err_o, sref_o and pdn_o go to zero, and cmd_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples everything |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column or mode word; bit 10 is the all-bank / auto-precharge flag |
| dqm | input | 2 | Byte data mask |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Protocol violation flag |
| act_o | output | 4 | Per-bank open flag |
| row_o | output | 48 | Open row of each bank, bank 0 in the low bits |
| col_o | output | 9 | Column of the last accepted read or write |
| mode_o | output | 14 | Captured mode word |
| sref_o | output | 1 | In self refresh |
| pdn_o | output | 1 | In power-down |
| rd_mask_o | output | 2 | Read data mask after its latency |

## Verification
A corrupted bank flag shows up on act_o right after the edge where it went wrong. It then causes a false or missing err_o on the very next activate, read or write aimed at that bank, one cycle after that command's edge. A wrong burst counter shows up as a bank that closes one edge early or late, or as a read sampled just inside the reservation window that is accepted when it should be rejected. A stuck lockout or low-power flag shows as errors on otherwise legal commands, or as ignored commands whose effect never reaches act_o.

// File: rtl/sdct_pkg.sv
package sdct_pkg;
  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DESEL    = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_AREF     = 4'd3,
    CMD_SREF_IN  = 4'd4,
    CMD_SREF_OUT = 4'd5,
    CMD_ACT      = 4'd6,
    CMD_RD       = 4'd7,
    CMD_WR       = 4'd8,
    CMD_PRE      = 4'd9,
    CMD_PALL     = 4'd10,
    CMD_BST      = 4'd11,
    CMD_PDN_IN   = 4'd12,
    CMD_PDN_OUT  = 4'd13,
    CMD_HOLD     = 4'd14
  } cmd_e;
endpackage

// File: rtl/sdct_decode.sv
module sdct_decode
  import sdct_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic in_sref,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cke_prev) begin
      if (cke) cmd = in_sref ? CMD_SREF_OUT : CMD_PDN_OUT;
      else     cmd = CMD_HOLD;
    end else if (!cke) begin
      if (!cs_n && !ras_n && !cas_n && we_n) cmd = CMD_SREF_IN;
      else                                   cmd = CMD_PDN_IN;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_AREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
        default: cmd = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdct_bank.sv
module sdct_bank #(
  parameter int ADDR_W = 12,
  parameter int BL_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              rw_i,
  input  logic              ap_i,
  input  logic [BL_W-1:0]   bl_i,
  input  logic [ADDR_W-1:0] row_i,
  output logic              active_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] row_o
);
  logic [BL_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      left_q   <= '0;
      row_o    <= '0;
    end else if (open_i) begin
      active_o <= 1'b1;
      row_o    <= row_i;
    end else if (close_i) begin
      active_o <= 1'b0;
      left_q   <= '0;
    end else if (rw_i && ap_i) begin
      left_q   <= bl_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      if (left_q == BL_W'(1)) active_o <= 1'b0;
    end
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/sdct_lock.sv
module sdct_lock #(
  parameter int LOCK_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(LOCK_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdct_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int ADDR_W     = 12,
  parameter int COL_W      = 9,
  parameter int AP_BIT     = 10,
  parameter int DQM_W      = 2,
  parameter int PAGE_WORDS = 256,
  parameter int LOCK_CYC   = 2,
  parameter int DQM_LAT    = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cke,
  input  logic                            cs_n,
  input  logic                            ras_n,
  input  logic                            cas_n,
  input  logic                            we_n,
  input  logic [BA_W-1:0]                 ba,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DQM_W-1:0]                dqm,
  output logic [3:0]                      cmd_o,
  output logic                            err_o,
  output logic [(1<<BA_W)-1:0]            act_o,
  output logic [(1<<BA_W)*ADDR_W-1:0]     row_o,
  output logic [COL_W-1:0]                col_o,
  output logic [BA_W+ADDR_W-1:0]          mode_o,
  output logic                            sref_o,
  output logic                            pdn_o,
  output logic [DQM_W-1:0]                rd_mask_o
);
  localparam int NBANK = 1 << BA_W;
  localparam int BL_W  = $clog2(PAGE_WORDS + 1);

  logic             cke_q;
  cmd_e             cmd;
  logic             lock;
  logic             err_now;
  logic [NBANK-1:0] sel, busy_v, open_v, close_v, rw_v;
  logic             hit_act, hit_busy, any_act;
  logic [BL_W-1:0]  bl;

  sdct_decode u_dec (
    .cke_prev (cke_q),
    .cke      (cke),
    .in_sref  (sref_o),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (addr[AP_BIT]),
    .cmd      (cmd)
  );

  assign sel      = NBANK'(1) << ba;
  assign hit_act  = |(act_o & sel);
  assign hit_busy = |(busy_v & sel);
  assign any_act  = |act_o;

  always_comb begin
    case (cmd)
      CMD_MRS, CMD_AREF, CMD_SREF_IN: err_now = lock || any_act;
      CMD_ACT:                        err_now = lock || hit_act;
      CMD_RD, CMD_WR:                 err_now = lock || !hit_act || hit_busy;
      CMD_PRE, CMD_PALL, CMD_BST:     err_now = lock;
      default:                        err_now = 1'b0;
    endcase
  end

  always_comb begin
    case (mode_o[2:0])
      3'b001:  bl = BL_W'(2);
      3'b010:  bl = BL_W'(4);
      3'b011:  bl = BL_W'(8);
      3'b111:  bl = BL_W'(PAGE_WORDS);
      default: bl = BL_W'(1);
    endcase
  end

  sdct_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .load_i (cmd == CMD_MRS && !err_now),
    .busy_o (lock)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign open_v[g]  = !err_now && cmd == CMD_ACT && sel[g];
    assign close_v[g] = !err_now && (cmd == CMD_PALL || (cmd == CMD_PRE && sel[g]));
    assign rw_v[g]    = !err_now && (cmd == CMD_RD || cmd == CMD_WR) && sel[g];

    sdct_bank #(.ADDR_W(ADDR_W), .BL_W(BL_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .open_i   (open_v[g]),
      .close_i  (close_v[g]),
      .rw_i     (rw_v[g]),
      .ap_i     (addr[AP_BIT]),
      .bl_i     (bl),
      .row_i    (addr),
      .active_o (act_o[g]),
      .busy_o   (busy_v[g]),
      .row_o    (row_o[g*ADDR_W +: ADDR_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b1;
      cmd_o  <= CMD_NOP;
      err_o  <= 1'b0;
      mode_o <= '0;
      col_o  <= '0;
      sref_o <= 1'b0;
      pdn_o  <= 1'b0;
    end else begin
      cke_q <= cke;
      cmd_o <= cmd;
      err_o <= err_now;
      if (cmd == CMD_MRS && !err_now) mode_o <= {ba, addr};
      if ((cmd == CMD_RD || cmd == CMD_WR) && !err_now) col_o <= addr[COL_W-1:0];
      case (cmd)
        CMD_SREF_IN: begin
          if (err_now) pdn_o  <= 1'b1;
          else         sref_o <= 1'b1;
        end
        CMD_SREF_OUT: sref_o <= 1'b0;
        CMD_PDN_IN:   pdn_o  <= 1'b1;
        CMD_PDN_OUT:  pdn_o  <= 1'b0;
        default: ;
      endcase
    end
  end

  logic [DQM_W-1:0] dq_pipe [DQM_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DQM_LAT; i++) dq_pipe[i] <= '0;
    end else begin
      dq_pipe[0] <= dqm;
      for (int i = 1; i < DQM_LAT; i++) dq_pipe[i] <= dq_pipe[i-1];
    end
  end

  assign rd_mask_o = dq_pipe[DQM_LAT-1];
endmodule

// File: rtl/sdct_chk.sv
module sdct_chk
  import sdct_pkg::*;
#(
  parameter int NB = 4,
  parameter int MW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    cmd_o,
  input logic          err_o,
  input logic [NB-1:0] act_o,
  input logic [MW-1:0] mode_o,
  input logic          sref_o,
  input logic          pdn_o
);
  function automatic logic is_ctl(input logic [3:0] c);
    return c == CMD_ACT || c == CMD_RD || c == CMD_WR || c == CMD_PRE ||
           c == CMD_PALL || c == CMD_MRS || c == CMD_AREF || c == CMD_BST;
  endfunction

  // R3 / R10: the mode word only changes while every bank was idle
  assert_mode_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_o) |-> ($past(act_o) == '0));

  // R5: a bank only opens through an accepted activate
  assert_open_by_act_R5: assert property (@(posedge clk) disable iff (rst)
    ((act_o & ~$past(act_o)) != '0) |-> (cmd_o == CMD_ACT && !err_o));

  // R4: first lockout edge after an accepted mode write
  assert_lock_first_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_MRS && !err_o) |=> (err_o || !is_ctl(cmd_o)));

  // R4: second lockout edge
  assert_lock_second_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_MRS && !err_o) |-> ##2 (err_o || !is_ctl(cmd_o)));

  // R2 / R3: self refresh is entered only with all banks idle
  assert_sref_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sref_o) |-> ($past(act_o) == '0 && cmd_o == CMD_SREF_IN));

  // R2: held commands never flag an error
  assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_HOLD) |-> !err_o);

  // R2: the two low-power states are exclusive
  always @(posedge clk) if (!rst) assert_lowpower_excl_R2: assert (!(sref_o && pdn_o));
endmodule

bind sdram_cmd_tracker sdct_chk #(.NB(1 << BA_W), .MW(BA_W + ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cmd_o  (cmd_o),
  .err_o  (err_o),
  .act_o  (act_o),
  .mode_o (mode_o),
  .sref_o (sref_o),
  .pdn_o  (pdn_o)
);

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
  localparam int CLK_P = 10;

  localparam logic [2:0] P_NOP = 3'b111, P_MRS = 3'b000, P_REF = 3'b001,
                         P_ACT = 3'b011, P_RD  = 3'b101, P_WR  = 3'b100,
                         P_PRE = 3'b010, P_BST = 3'b110;

  localparam int C_NOP = 0, C_DESEL = 1, C_MRS = 2, C_AREF = 3, C_SIN = 4,
                 C_SOUT = 5, C_ACT = 6, C_RD = 7, C_WR = 8, C_PRE = 9,
                 C_PALL = 10, C_BST = 11, C_PIN = 12, C_POUT = 13, C_HOLD = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [1:0]  dqm = '0;
  logic [3:0]  cmd_o;
  logic        err_o;
  logic [3:0]  act_o;
  logic [47:0] row_o;
  logic [8:0]  col_o;
  logic [13:0] mode_o;
  logic        sref_o, pdn_o;
  logic [1:0]  rd_mask_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .cmd_o(cmd_o), .err_o(err_o),
    .act_o(act_o), .row_o(row_o), .col_o(col_o), .mode_o(mode_o),
    .sref_o(sref_o), .pdn_o(pdn_o), .rd_mask_o(rd_mask_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [2:0] p, input logic [1:0] b, input logic [11:0] a);
    cs_n = 1'b0;
    {ras_n, cas_n, we_n} = p;
    ba = b;
    addr = a;
    step();
    {ras_n, cas_n, we_n} = P_NOP;
    ba = '0;
    addr = '0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0]  e_act;
    logic [11:0] e_row [4];

    repeat (3) step();
    // R12 reset state
    chk("R12 act", act_o, 0);
    chk("R12 cmd", cmd_o, C_NOP);
    chk("R12 mode", mode_o, 0);
    chk("R12 err", err_o, 0);
    chk("R12 lowpower", {sref_o, pdn_o}, 0);
    chk("R12 mask", rd_mask_o, 0);
    rst = 1'b0;
    step();

    // R1 decoding of plain commands
    cs_n = 1'b1; step(); cs_n = 1'b0;
    chk("R1 deselect", cmd_o, C_DESEL);
    put(P_BST, 0, 0);
    chk("R1 burst stop", {err_o, cmd_o}, C_BST);
    put(P_NOP, 0, 0);
    chk("R1 nop", cmd_o, C_NOP);

    // R10 mode capture, burst length 4
    put(P_MRS, 2'b01, 12'h032);
    chk("R10 mode", mode_o, 14'h1032);
    chk("R1 mrs code", {err_o, cmd_o}, C_MRS);
    // R4 lockout for two edges
    put(P_ACT, 0, 12'h123);
    chk("R4 lock edge1 err", err_o, 1);
    chk("R4 lock edge1 act", act_o, 0);
    put(P_ACT, 0, 12'h123);
    chk("R4 lock edge2 err", err_o, 1);
    put(P_ACT, 0, 12'h123);
    chk("R4 after lock", {err_o, act_o}, 5'b0_0001);
    chk("R5 row0", row_o[11:0], 12'h123);

    // R8 auto precharge, BL=4
    put(P_ACT, 1, 12'h456);
    chk("R5 act bank1", act_o, 4'b0011);
    put(P_RD, 1, 12'h405);
    chk("R6 col", {err_o, col_o}, 10'h005);
    chk("R1 read code", cmd_o, C_RD);
    put(P_RD, 1, 12'h006);
    chk("R8 busy read err", err_o, 1);
    chk("R8 busy read col", col_o, 9'h005);
    put(P_ACT, 1, 12'h777);
    chk("R8 busy act err", err_o, 1);
    put(P_NOP, 0, 0);
    chk("R8 open at edge3", act_o, 4'b0011);
    chk("R9 err one cycle", err_o, 0);
    put(P_NOP, 0, 0);
    chk("R8 closed at edge4", act_o, 4'b0001);

    // R3 illegal mode write / refresh with an open bank
    put(P_MRS, 0, 12'h000);
    chk("R3 mrs err", err_o, 1);
    chk("R3 mode kept", mode_o, 14'h1032);
    put(P_REF, 0, 0);
    chk("R3 aref err", {err_o, cmd_o}, {1'b1, 4'(C_AREF)});

    // R7 single and all-bank precharge
    put(P_ACT, 3, 12'h777);
    chk("R5 row3", row_o[47:36], 12'h777);
    put(P_PRE, 3, 12'h000);
    chk("R7 single", {cmd_o, act_o}, {4'(C_PRE), 4'b0001});
    put(P_PRE, 2, 12'h400);
    chk("R7 all", {err_o, cmd_o, act_o}, {1'b0, 4'(C_PALL), 4'b0000});
    put(P_REF, 0, 0);
    chk("R3 aref ok", {err_o, cmd_o}, C_AREF);

    // R8 auto precharge with BL=1
    put(P_MRS, 0, 12'h000);
    put(P_NOP, 0, 0);
    put(P_NOP, 0, 0);
    put(P_ACT, 2, 12'h0AA);
    put(P_WR, 2, 12'h411);
    chk("R8 bl1 open", {err_o, cmd_o, act_o}, {1'b0, 4'(C_WR), 4'b0100});
    put(P_NOP, 0, 0);
    chk("R8 bl1 closed", act_o, 0);

    // R2 self refresh and power-down
    cke = 1'b0;
    put(P_REF, 0, 0);
    chk("R2 sref entry", {cmd_o, sref_o, pdn_o}, {4'(C_SIN), 2'b10});
    put(P_ACT, 0, 12'h111);
    chk("R2 held", {err_o, cmd_o, act_o}, {1'b0, 4'(C_HOLD), 4'b0000});
    cke = 1'b1;
    put(P_NOP, 0, 0);
    chk("R2 sref exit", {cmd_o, sref_o}, {4'(C_SOUT), 1'b0});
    cke = 1'b0;
    put(P_NOP, 0, 0);
    chk("R2 pdn entry", {cmd_o, pdn_o}, {4'(C_PIN), 1'b1});
    cke = 1'b1;
    put(P_NOP, 0, 0);
    chk("R2 pdn exit", {cmd_o, pdn_o}, {4'(C_POUT), 1'b0});
    put(P_ACT, 0, 12'h222);
    cke = 1'b0;
    put(P_REF, 0, 0);
    chk("R3 sref illegal", {err_o, sref_o, pdn_o}, 3'b101);
    cke = 1'b1;
    put(P_NOP, 0, 0);
    chk("R2 exit pdn", {cmd_o, pdn_o}, {4'(C_POUT), 1'b0});
    put(P_PRE, 0, 12'h400);

    // R11 read mask latency
    dqm = 2'b11;
    step();
    dqm = 2'b00;
    chk("R11 edge n", rd_mask_o, 0);
    step();
    chk("R11 edge n+1", rd_mask_o, 2'b11);
    step();
    chk("R11 edge n+2", rd_mask_o, 0);

    // R5 R6 R7 sweep: every bank, both starting states, four operations
    e_act = '0;
    for (int i = 0; i < 4; i++) e_row[i] = 12'h000;
    for (int b = 0; b < 4; b++) begin
      for (int pre = 0; pre < 2; pre++) begin
        for (int op = 0; op < 4; op++) begin
          logic        e_err;
          logic [11:0] nr;
          put(P_PRE, 0, 12'h400);
          e_act = '0;
          if (pre == 1) begin
            put(P_ACT, 2'(b), 12'(12'h050 + b));
            e_act[b] = 1'b1;
            e_row[b] = 12'(12'h050 + b);
          end
          nr = 12'(12'h800 + b * 16 + op);
          case (op)
            0: begin
              put(P_ACT, 2'(b), nr);
              e_err = (pre == 1);
              if (!e_err) begin e_act[b] = 1'b1; e_row[b] = nr; end
              chk("R5 sweep act err", err_o, e_err);
            end
            1, 2: begin
              put(op == 1 ? P_RD : P_WR, 2'(b), 12'(12'h0A0 + b));
              e_err = (pre == 0);
              chk("R6 sweep rw err", err_o, e_err);
              if (!e_err) chk("R6 sweep col", col_o, 9'(9'h0A0 + b));
            end
            default: begin
              put(P_PRE, 2'(b), 12'h000);
              e_act[b] = 1'b0;
              chk("R7 sweep pre err", err_o, 0);
            end
          endcase
          chk("R5 sweep banks", act_o, e_act);
          if (e_act[b]) chk("R5 sweep row", row_o[b*12 +: 12], e_row[b]);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule